// File: doc/BRIEF.md
# Decoded-Instruction Router for a Four-Core SIMD/MIMD Cluster

This block sits between the decode and execute stages of a cluster of four 32-bit processors. Its job is to choose where each execute stage takes its decoded instruction from. The cluster has two modes. In MIMD mode every core runs on its own: each execute stage takes the output of its own decoder. In SIMD mode, lane 0 is the master. Its decoded instruction is forwarded to every participating execute stage in the same cycle, and the fetch/decode front ends of lanes 1 to 3 have their clock enables removed, so they issue no instruction-memory requests. The data path does not change in either mode, and every execute stage keeps using its own local register file.

The master's instruction stream carries a reconfiguration instruction that switches the mode. The decoder marks it with a flag and a target-mode bit. The switch takes effect on the clock edge at which the instruction is accepted. The cluster may enter SIMD mode only once all cores report that they are synchronized. A request to enter SIMD mode that arrives without synchronization is held until the synchronized flag rises. A participation mask picks which slave lanes execute the broadcast. Lanes left out of the mask receive a no-operation instead.

The controller is a three-state machine:
- `ST_MIMD`: independent cores. This is the reset state.
- `ST_PEND`: a SIMD request is waiting for synchronization. Routing is the same as in MIMD.
- `ST_SIMD`: master broadcast.

The transitions are:
- `ST_MIMD -> ST_SIMD` when a SIMD request is accepted and the cores are synchronized.
- `ST_MIMD -> ST_PEND` when a SIMD request is accepted without synchronization.
- `ST_PEND -> ST_SIMD` when the synchronized flag is high.
- `ST_PEND -> ST_MIMD` when an accepted MIMD request cancels the pending one.
- `ST_SIMD -> ST_MIMD` when a MIMD request is accepted.

Top module: `dec_router`

## Requirements
- R1: After reset, `simd_mode` is 0, all four `fe_en` bits are 1, and routing follows R2.
- R2: Outside SIMD mode, each lane passes through on its own. For every lane i, `ex_insn` lane i equals `dec_insn` lane i, `ex_valid[i]` equals `dec_valid[i]`, and `dec_stall[i]` equals `ex_stall[i]`. Lane i occupies bits [32i+31:32i] of each instruction bus.
- R3: In SIMD mode, lane 0 and every slave lane whose mask bit is set receive `dec_insn` lane 0 in the same cycle. Slave lane i uses `part_mask[i-1]`.
- R4: In SIMD mode, `fe_en[3:1]` are 0, `fe_en[0]` stays 1, and `dec_stall[3:1]` are 1.
- R5: A reconfiguration instruction is accepted when `cfg_req`, `dec_valid[0]` are high and `dec_stall[0]` is low. If it is accepted with `cfg_simd`=1 while `sync_ok` is high, `simd_mode` reads 1 from the next cycle on.
- R6: A SIMD request accepted while `sync_ok` is low is held pending, and routing stays as in R2. The mode becomes SIMD in the cycle after the first cycle in which `sync_ok` is high. An accepted MIMD request cancels the pending request.
- R7: In SIMD mode, any `ex_stall` bit forces `dec_stall[0]` to 1 and all `ex_valid` bits to 0. With no stall, all four `ex_valid` bits equal `dec_valid[0]`.
- R8: If a reconfiguration instruction with `cfg_simd`=0 is accepted in SIMD mode, `simd_mode` reads 0 in the next cycle. In that same next cycle, all `fe_en` bits are 1 again.
- R9: In SIMD mode, a slave lane whose mask bit is clear receives the no-operation encoding, which is all zeros by default, with the same valid as the broadcast.
- R10: A request for the mode that is already active has no effect. So does a `cfg_req` that is not accepted, that is, one without `dec_valid[0]` or one during a master stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_insn | input | 128 | Decoded instruction from each lane's decoder |
| dec_valid | input | 4 | Decoder output valid, per lane |
| ex_stall | input | 4 | Execute stage cannot accept, per lane |
| cfg_req | input | 1 | Master's decoded instruction is a reconfiguration |
| cfg_simd | input | 1 | Target mode of the reconfiguration (1 = SIMD) |
| sync_ok | input | 1 | All participating cores have met the barrier |
| part_mask | input | 3 | Slave lanes 1..3 that execute the broadcast |
| ex_insn | output | 128 | Instruction delivered to each execute stage |
| ex_valid | output | 4 | Execute-stage instruction valid, per lane |
| dec_stall | output | 4 | Hold signal back to each decoder |
| fe_en | output | 4 | Fetch/decode clock enable, per lane |
| simd_mode | output | 1 | 1 while the cluster runs in SIMD mode |

## Verification
The assertions check these properties on every cycle:
- the broadcast reaches each participating lane, and non-participants get the no-operation;
- slave front ends are gated and frozen in SIMD mode;
- lockstep stalls;
- SIMD mode is never entered without a prior synchronized cycle;
- the one-cycle exit, together with the return of the front-end enables.

Only the bench scenarios can show the following:
- the exact cycle at which a request takes effect;
- a pending request waiting through several unsynchronized cycles, and its cancellation;
- that requests which are refused or target the current mode leave the routing untouched.

// File: rtl/dec_router_pkg.sv
package dec_router_pkg;
    typedef enum logic [1:0] {
        ST_MIMD = 2'd0,
        ST_PEND = 2'd1,
        ST_SIMD = 2'd2
    } route_mode_e;
endpackage

// File: rtl/dec_router_fsm.sv
module dec_router_fsm
    import dec_router_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_fire,
    input  logic        cfg_simd,
    input  logic        sync_ok,
    output route_mode_e state,
    output logic        simd
);
    route_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MIMD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MIMD: if (cfg_fire && cfg_simd) state_d = sync_ok ? ST_SIMD : ST_PEND;
            ST_PEND: begin
                if (cfg_fire && !cfg_simd) state_d = ST_MIMD;
                else if (sync_ok)          state_d = ST_SIMD;
            end
            ST_SIMD: if (cfg_fire && !cfg_simd) state_d = ST_MIMD;
            default: state_d = ST_MIMD;
        endcase
    end

    always_comb begin
        state = state_q;
        simd  = (state_q == ST_SIMD);
    end

    // R6: SIMD entry only follows a synchronized cycle
    a_r6_entry_synced: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(simd) |-> $past(sync_ok));

    // R8: an accepted MIMD request leaves SIMD on the next edge
    a_r8_exit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (simd && cfg_fire && !cfg_simd) |=> !simd);

    // R5: synchronized SIMD request taken in one cycle
    a_r5_enter_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MIMD && cfg_fire && cfg_simd && sync_ok) |=> simd);
endmodule

// File: rtl/dec_router_lanes.sv
module dec_router_lanes #(
    parameter int          LANES  = 4,
    parameter int          INSN_W = 32,
    parameter logic [31:0] NOP    = 32'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    simd,
    input  logic [LANES-2:0]        part_mask,
    input  logic [LANES*INSN_W-1:0] dec_insn,
    input  logic [LANES-1:0]        dec_valid,
    input  logic [LANES-1:0]        ex_stall,
    output logic [LANES*INSN_W-1:0] ex_insn,
    output logic [LANES-1:0]        ex_valid,
    output logic [LANES-1:0]        dec_stall
);
    localparam logic [INSN_W-1:0] NOP_W = INSN_W'(NOP);

    logic [LANES-1:0]  joins;
    logic              any_stall;
    logic              bcast_go;
    logic [INSN_W-1:0] master_insn;

    always_comb begin
        joins       = {part_mask, 1'b1};
        any_stall   = |ex_stall;
        bcast_go    = dec_valid[0] && !any_stall;
        master_insn = dec_insn[INSN_W-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (simd) begin
                ex_insn[g*INSN_W +: INSN_W] = joins[g] ? master_insn : NOP_W;
                ex_valid[g]                 = bcast_go;
                dec_stall[g]                = (g == 0) ? any_stall : 1'b1;
            end else begin
                ex_insn[g*INSN_W +: INSN_W] = dec_insn[g*INSN_W +: INSN_W];
                ex_valid[g]                 = dec_valid[g];
                dec_stall[g]                = ex_stall[g];
            end
        end

        if (g > 0) begin : g_chk
            // R3: participants see the master's decode
            a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
                (simd && part_mask[g-1]) |-> ex_insn[g*INSN_W +: INSN_W] == dec_insn[INSN_W-1:0]);
            // R9: non-participants see the no-operation
            a_r9_nop_fill: assert property (@(posedge clk) disable iff (!rst_n)
                (simd && !part_mask[g-1]) |-> ex_insn[g*INSN_W +: INSN_W] == NOP_W);
        end
    end

    // R7: lockstep - any stall holds the master and blocks every lane
    a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (simd && (ex_stall != '0)) |-> (dec_stall[0] && ex_valid == '0));
endmodule

// File: rtl/dec_router_gate.sv
module dec_router_gate #(
    parameter int LANES = 4
) (
    input  logic             simd,
    output logic [LANES-1:0] fe_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_en
        if (g == 0) begin : g_master
            assign fe_en[g] = 1'b1;
        end else begin : g_slave
            assign fe_en[g] = !simd;
        end
    end
endmodule

// File: rtl/dec_router.sv
module dec_router
    import dec_router_pkg::*;
#(
    parameter int          LANES  = 4,
    parameter int          INSN_W = 32,
    parameter logic [31:0] NOP    = 32'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*INSN_W-1:0] dec_insn,
    input  logic [LANES-1:0]        dec_valid,
    input  logic [LANES-1:0]        ex_stall,
    input  logic                    cfg_req,
    input  logic                    cfg_simd,
    input  logic                    sync_ok,
    input  logic [LANES-2:0]        part_mask,
    output logic [LANES*INSN_W-1:0] ex_insn,
    output logic [LANES-1:0]        ex_valid,
    output logic [LANES-1:0]        dec_stall,
    output logic [LANES-1:0]        fe_en,
    output logic                    simd_mode
);
    route_mode_e state;
    logic        simd;
    logic        cfg_fire;

    assign cfg_fire  = cfg_req && dec_valid[0] && !dec_stall[0];
    assign simd_mode = simd;

    dec_router_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_fire (cfg_fire),
        .cfg_simd (cfg_simd),
        .sync_ok  (sync_ok),
        .state    (state),
        .simd     (simd)
    );

    dec_router_lanes #(.LANES(LANES), .INSN_W(INSN_W), .NOP(NOP)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .simd      (simd),
        .part_mask (part_mask),
        .dec_insn  (dec_insn),
        .dec_valid (dec_valid),
        .ex_stall  (ex_stall),
        .ex_insn   (ex_insn),
        .ex_valid  (ex_valid),
        .dec_stall (dec_stall)
    );

    dec_router_gate #(.LANES(LANES)) u_gate (
        .simd  (simd),
        .fe_en (fe_en)
    );

    // R4: slave front ends gated and frozen during SIMD
    a_r4_slaves_gated: assert property (@(posedge clk) disable iff (!rst_n)
        simd_mode |-> (fe_en[LANES-1:1] == '0 && dec_stall[LANES-1:1] == '1 && fe_en[0]));

    // R8: enables come back with the first MIMD cycle
    a_r8_fe_restored: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(simd_mode) |-> fe_en == '1);

    // R2: pending state keeps independent routing
    a_r2_pend_independent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND) |-> (ex_valid == dec_valid && dec_stall == ex_stall));
endmodule

// File: tb/dec_router_bench.sv
module dec_router_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] dec_insn;
    logic [3:0]   dec_valid, ex_stall;
    logic         cfg_req, cfg_simd, sync_ok;
    logic [2:0]   part_mask;
    logic [127:0] ex_insn;
    logic [3:0]   ex_valid, dec_stall, fe_en;
    logic         simd_mode;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dec_router u_dec_router (
        .clk(clk), .rst_n(rst_n), .dec_insn(dec_insn), .dec_valid(dec_valid),
        .ex_stall(ex_stall), .cfg_req(cfg_req), .cfg_simd(cfg_simd),
        .sync_ok(sync_ok), .part_mask(part_mask), .ex_insn(ex_insn),
        .ex_valid(ex_valid), .dec_stall(dec_stall), .fe_en(fe_en),
        .simd_mode(simd_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_insn  = {32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000};
        dec_valid = 4'hF;
        ex_stall  = 4'h0;
        cfg_req   = 1'b0;
        cfg_simd  = 1'b0;
        sync_ok   = 1'b0;
        part_mask = 3'b111;
    endtask

    // issue one reconfiguration through the master and move to the next cycle
    task automatic reconf(input logic tgt, input logic sync);
        @(negedge clk);
        idle();
        cfg_req = 1'b1; cfg_simd = tgt; sync_ok = sync;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic t_reset();
        idle();
        #1;
        chk(simd_mode == 1'b0, "R1 mode", simd_mode, 0);
        chk(fe_en == 4'hF, "R1 fe_en", fe_en, 4'hF);
        chk(ex_insn == dec_insn, "R1 routing", ex_insn, dec_insn);
    endtask

    task automatic t_mimd();
        @(negedge clk);
        idle();
        dec_valid = 4'b1010; ex_stall = 4'b0110;
        #1;
        chk(ex_insn == dec_insn, "R2 insn", ex_insn, dec_insn);
        chk(ex_valid == 4'b1010, "R2 valid", ex_valid, 4'b1010);
        chk(dec_stall == 4'b0110, "R2 stall", dec_stall, 4'b0110);
    endtask

    task automatic t_enter();
        @(negedge clk);
        idle();
        cfg_req = 1'b1; cfg_simd = 1'b1; sync_ok = 1'b1;
        #1;
        chk(simd_mode == 1'b0, "R5 not before edge", simd_mode, 0);
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b1, "R5 mode next cycle", simd_mode, 1);
        chk(fe_en == 4'b0001, "R4 fe_en", fe_en, 4'b0001);
        chk(dec_stall == 4'b1110, "R4 slave stall", dec_stall, 4'b1110);
        chk(ex_insn == {4{32'hA0A0_0000}}, "R3 broadcast", ex_insn, {4{32'hA0A0_0000}});
        chk(ex_valid == 4'hF, "R7 valid no stall", ex_valid, 4'hF);
    endtask

    task automatic t_mask();
        @(negedge clk);
        idle();
        part_mask = 3'b010;
        dec_insn[31:0] = 32'h1234_5678;
        #1;
        chk(ex_insn == {32'h0, 32'h1234_5678, 32'h0, 32'h1234_5678}, "R9 mask",
            ex_insn, {32'h0, 32'h1234_5678, 32'h0, 32'h1234_5678});
        chk(ex_valid == 4'hF, "R9 valid", ex_valid, 4'hF);
    endtask

    task automatic t_stall();
        @(negedge clk);
        idle();
        ex_stall = 4'b0100;
        #1;
        chk(dec_stall[0] == 1'b1, "R7 master held", dec_stall[0], 1);
        chk(ex_valid == 4'h0, "R7 valid blocked", ex_valid, 0);
        // stalled reconfig is not accepted
        cfg_req = 1'b1; cfg_simd = 1'b0;
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b1, "R10 stalled request", simd_mode, 1);
    endtask

    task automatic t_same_mode();
        reconf(1'b1, 1'b1);
        chk(simd_mode == 1'b1, "R10 SIMD in SIMD", simd_mode, 1);
    endtask

    task automatic t_exit();
        @(negedge clk);
        idle();
        cfg_req = 1'b1; cfg_simd = 1'b0;
        #1;
        chk(fe_en == 4'b0001, "R8 gated on switch cycle", fe_en, 4'b0001);
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b0, "R8 mode", simd_mode, 0);
        chk(fe_en == 4'hF, "R8 fe_en", fe_en, 4'hF);
        chk(ex_insn == dec_insn, "R8 independent", ex_insn, dec_insn);
    endtask

    task automatic t_pending();
        reconf(1'b1, 1'b0);
        chk(simd_mode == 1'b0, "R6 held", simd_mode, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle();
            #1;
            chk(simd_mode == 1'b0 && ex_insn == dec_insn, "R6 waiting", simd_mode, 0);
        end
        @(negedge clk);
        idle();
        sync_ok = 1'b1;
        #1;
        chk(simd_mode == 1'b0, "R6 sync cycle", simd_mode, 0);
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b1, "R6 entered", simd_mode, 1);
        reconf(1'b0, 1'b0);
        chk(simd_mode == 1'b0, "R8 back", simd_mode, 0);
        // cancel
        reconf(1'b1, 1'b0);
        reconf(1'b0, 1'b0);
        @(negedge clk);
        idle();
        sync_ok = 1'b1;
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b0, "R6 cancelled", simd_mode, 0);
    endtask

    task automatic t_ignored();
        reconf(1'b0, 1'b1);
        chk(simd_mode == 1'b0, "R10 MIMD in MIMD", simd_mode, 0);
        @(negedge clk);
        idle();
        cfg_req = 1'b1; cfg_simd = 1'b1; sync_ok = 1'b1; dec_valid = 4'b1110;
        @(negedge clk);
        idle();
        #1;
        chk(simd_mode == 1'b0, "R10 no valid", simd_mode, 0);
        chk(fe_en == 4'hF, "R10 fe_en", fe_en, 4'hF);
    endtask

    initial begin
        idle();
        #9 rst_n = 1'b1;
        t_reset();
        t_mimd();
        t_enter();
        t_mask();
        t_stall();
        t_same_mode();
        t_exit();
        t_pending();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #20000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule